// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block owns a free-running up-counter of `TMR_W` bits and a compare register of the same width. While one of the four compare modes is selected, it checks the counter against the compare register on every clock. On a match it can set or clear an output latch, raise only a sticky match flag, or emit a one-cycle trigger that restarts the counter. In the last case the compare register becomes the counter's period register, and the trigger can start work in a neighbouring block.

The counter keeps its own sticky wrap flag, so that the way the trigger and the natural rollover interact can be seen at the ports. Software writes the compare value and the 4-bit mode through write strobes and clears each flag with its own strobe. A hold input freezes the counter and the matching logic.

Top module: `tcu_compare_unit`

## Requirements
- R1: After reset the counter, the output latch, both flags and the trigger are all 0, and the mode is off (4'b0000).
- R2: In mode 4'b1010, a cycle where the counter equals the compare value sets `match_flag` at the next clock edge and leaves `cmp_pin` unchanged.
- R3: Writing mode 4'b1000 forces `cmp_pin` low at the next edge. A later match in that mode drives it high.
- R4: Writing mode 4'b1001 forces `cmp_pin` high at the next edge. A later match in that mode drives it low.
- R5: In mode 4'b1011 a match sets `match_flag`, raises `trig_pulse` for exactly one cycle and restarts the counter at 0 on the same edge, so the counter runs through compare+1 states (compare value of 1 or more).
- R6: A counter advance from all-ones sets `ovf_flag`. A restart by the trigger from any other value does not set it.
- R7: With the compare value all-ones in mode 4'b1011, the match and the wrap fall on the same edge, and both `match_flag` and `ovf_flag` are set.
- R8: Writing mode 4'b0000 forces `cmp_pin` low at the next edge.
- R9: While `hold` is high the counter does not advance, no match is detected, no flag is set, no trigger is issued, and `cmp_pin` keeps its level unless the mode is written.
- R10: A clear strobe clears its flag at the next edge. If the flag's set condition occurs in the same cycle, the set wins.
- R11: A compare write is used from the cycle after the write, without waiting for a period boundary.
- R12: Modes other than 4'b1000 to 4'b1011 detect no match: no flag, no trigger and no pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Freezes the counter and the matching logic |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | TMR_W | Compare value to write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value to write |
| match_clr | input | 1 | Clears `match_flag` |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| timer_value | output | TMR_W | Current counter value |
| cmp_pin | output | 1 | Compare output latch |
| trig_pulse | output | 1 | One-cycle period trigger |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky counter wrap flag |

## Verification
Every result is registered once. A match seen in cycle N shows on the flag, the pin, the trigger and the restarted counter right after edge N+1, and a mode or compare write lands on the same edge. The bench applies each stimulus between edges, waits for one rising edge and samples 1 ns later. It compares the ports against a per-cycle model built from the requirements, so each expected value belongs to exactly the edge that produced it. The sweeps use an 8-bit counter, so every rollover and the all-ones match can be reached in a few hundred cycles.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

   typedef enum logic [3:0] {
      MODE_OFF         = 4'b0000,
      MODE_DRIVE_HI    = 4'b1000,
      MODE_DRIVE_LO    = 4'b1001,
      MODE_FLAG_ONLY   = 4'b1010,
      MODE_PERIOD_TRIG = 4'b1011
   } tcu_mode_e;

   localparam int unsigned MODE_W = 4;

   function automatic logic mode_compares(input logic [MODE_W-1:0] m);
      return (m[3:2] == 2'b10);
   endfunction

endpackage

// File: rtl/tcu_timer.sv
module tcu_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         restart,
   input  logic         ovf_clr,
   output logic [W-1:0] count,
   output logic         ovf_flag
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (W < 2) begin : g_bad_width
         $error("tcu_timer: W must be at least 2");
      end
   endgenerate

   logic wrap;
   assign wrap = advance && (count == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (advance) begin
         count <= restart ? '0 : count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ovf_flag <= 1'b0;
      else if (wrap)     ovf_flag <= 1'b1;
      else if (ovf_clr)  ovf_flag <= 1'b0;
   end

   // R9: a frozen counter keeps its value
   a_r9_hold_timer: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> (count == $past(count)));

   // R6: a restart away from all-ones is not a wrap
   a_r6_restart_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && restart && (count != TOP) && !ovf_flag) |=> !ovf_flag);

   // R6: an advance from all-ones sets the wrap flag
   a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && (count == TOP)) |=> ovf_flag);

endmodule

// File: rtl/tcu_match.sv
module tcu_match
   import tcu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic              enable,
   input  logic [W-1:0]      count,
   input  logic [W-1:0]      cmp_val,
   input  logic [MODE_W-1:0] mode,
   output logic              hit,
   output logic              trig_hit
);
   assign hit      = enable && mode_compares(mode) && (count == cmp_val);
   assign trig_hit = hit && (mode == MODE_PERIOD_TRIG);
endmodule

// File: rtl/tcu_pin.sv
module tcu_pin
   import tcu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic [MODE_W-1:0] mode,
   input  logic              hit,
   output logic              pin
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin <= 1'b0;
      end else if (mode_wr) begin
         case (mode_wdata)
            MODE_OFF:      pin <= 1'b0;
            MODE_DRIVE_HI: pin <= 1'b0;
            MODE_DRIVE_LO: pin <= 1'b1;
            default:       pin <= pin;
         endcase
      end else if (hit) begin
         case (mode)
            MODE_DRIVE_HI: pin <= 1'b1;
            MODE_DRIVE_LO: pin <= 1'b0;
            default:       pin <= pin;
         endcase
      end
   end

   // R3: a match in the drive-high mode sets the latch
   a_r3_match_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && hit && (mode == MODE_DRIVE_HI)) |=> pin);

   // R4: a match in the drive-low mode clears the latch
   a_r4_match_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && hit && (mode == MODE_DRIVE_LO)) |=> !pin);

   // R4: entering drive-low starts from the high level
   a_r4_entry_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (mode_wdata == MODE_DRIVE_LO)) |=> pin);

   // R8: turning the unit off returns the latch to low
   a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (mode_wdata == MODE_OFF)) |=> !pin);

endmodule

// File: rtl/tcu_compare_unit.sv
module tcu_compare_unit
   import tcu_pkg::*;
#(
   parameter int unsigned TMR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              cmp_wr,
   input  logic [TMR_W-1:0]  cmp_wdata,
   input  logic              mode_wr,
   input  logic [3:0]        mode_wdata,
   input  logic              match_clr,
   input  logic              ovf_clr,
   output logic [TMR_W-1:0]  timer_value,
   output logic              cmp_pin,
   output logic              trig_pulse,
   output logic              match_flag,
   output logic              ovf_flag
);
   localparam logic [TMR_W-1:0] ALL_ONES = '1;

   logic [TMR_W-1:0]  cmp_q;
   logic [MODE_W-1:0] mode_q;
   logic              hit;
   logic              trig_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         mode_q <= MODE_OFF;
      end else begin
         if (cmp_wr)  cmp_q  <= cmp_wdata;
         if (mode_wr) mode_q <= mode_wdata;
      end
   end

   tcu_timer #(.W(TMR_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (!hold),
      .restart  (trig_hit),
      .ovf_clr  (ovf_clr),
      .count    (timer_value),
      .ovf_flag (ovf_flag)
   );

   tcu_match #(.W(TMR_W)) match_i (
      .enable   (!hold),
      .count    (timer_value),
      .cmp_val  (cmp_q),
      .mode     (mode_q),
      .hit      (hit),
      .trig_hit (trig_hit)
   );

   tcu_pin pin_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .mode       (mode_q),
      .hit        (hit),
      .pin        (cmp_pin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_flag <= 1'b0;
         trig_pulse <= 1'b0;
      end else begin
         trig_pulse <= trig_hit;
         if (hit)            match_flag <= 1'b1;
         else if (match_clr) match_flag <= 1'b0;
      end
   end

   // R2: a detected match leaves the flag set
   a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> match_flag);

   // R5: the trigger comes with the counter back at zero
   a_r5_trig_zero: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> (timer_value == '0));

   // R7: an all-ones period sets both flags together
   a_r7_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hit && (cmp_q == ALL_ONES)) |=> (match_flag && ovf_flag));

   // R9: no trigger follows a held cycle
   a_r9_hold_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !trig_pulse);

   // R10: a clear without a coinciding match empties the flag
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (match_clr && !hit) |=> !match_flag);

   // R12: a non-compare mode never triggers
   a_r12_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_compares(mode_q) |=> !trig_pulse);

endmodule

// File: tb/tcu_compare_unit_tb.sv
`timescale 1ns/1ps
module tcu_compare_unit_tb_top;
   localparam int W   = 8;
   localparam int MAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hold = 1'b0;
   logic         cmp_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic         mode_wr = 1'b0;
   logic [3:0]   mode_wdata = '0;
   logic         match_clr = 1'b0;
   logic         ovf_clr = 1'b0;
   logic [W-1:0] timer_value;
   logic         cmp_pin, trig_pulse, match_flag, ovf_flag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference state
   int m_cnt = 0, m_cmp = 0, m_mode = 0;
   bit m_out = 0, m_mf = 0, m_of = 0, m_trig = 0;
   logic [15:0] lf = 16'hACE1;

   always #2.5 clk = ~clk;

   tcu_compare_unit #(.TMR_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .hold(hold), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata), .match_clr(match_clr), .ovf_clr(ovf_clr),
      .timer_value(timer_value), .cmp_pin(cmp_pin), .trig_pulse(trig_pulse),
      .match_flag(match_flag), .ovf_flag(ovf_flag)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      chk(req, "timer_value", int'(timer_value), m_cnt);
      chk(req, "cmp_pin",     int'(cmp_pin),     int'(m_out));
      chk(req, "trig_pulse",  int'(trig_pulse),  int'(m_trig));
      chk(req, "match_flag",  int'(match_flag),  int'(m_mf));
      chk(req, "ovf_flag",    int'(ovf_flag),    int'(m_of));
   endtask

   task automatic step(input bit h, input bit cw, input int cd, input bit mw, input int md,
                       input bit mc, input bit oc, input string req);
      bit is_cmp, hit, wrap;
      hold = h; cmp_wr = cw; cmp_wdata = W'(cd); mode_wr = mw; mode_wdata = 4'(md);
      match_clr = mc; ovf_clr = oc;
      @(posedge clk);
      is_cmp = (m_mode >= 8) && (m_mode <= 11);
      hit    = !h && is_cmp && (m_cnt == m_cmp);
      wrap   = !h && (m_cnt == MAX);
      m_trig = hit && (m_mode == 11);
      if (wrap) m_of = 1; else if (oc) m_of = 0;
      if (hit)  m_mf = 1; else if (mc) m_mf = 0;
      if (mw) begin
         if (md == 9) m_out = 1;
         else if (md == 8 || md == 0) m_out = 0;
      end else if (hit) begin
         if (m_mode == 8) m_out = 1;
         else if (m_mode == 9) m_out = 0;
      end
      if (!h) m_cnt = m_trig ? 0 : ((m_cnt + 1) & MAX);
      if (mw) m_mode = md;
      if (cw) m_cmp = cd;
      #1;
      compare_all(req);
      hold = 0; cmp_wr = 0; mode_wr = 0; match_clr = 0; ovf_clr = 0;
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: values straight out of reset
      compare_all("R1");

      // R6: free run in off mode wraps and sets the wrap flag; R12 no match
      idle(300, "R6");
      step(0, 0, 0, 0, 0, 0, 1, "R10");
      // R12: capture-like and upper codes never match
      step(0, 1, 40, 1, 4'b0100, 0, 0, "R12");
      idle(300, "R12");
      step(0, 0, 0, 1, 4'b1100, 0, 0, "R12");
      idle(300, "R12");
      step(0, 0, 0, 0, 0, 1, 1, "R10");

      // R2 / R11: flag-only mode over a sweep of compare values, writes mid-run
      step(0, 0, 0, 1, 4'b1010, 0, 0, "R2");
      for (int c = 0; c <= MAX; c += 17) begin
         step(0, 1, c, 0, 0, 1, 1, "R11");
         for (int i = 0; i < 260; i++)
            step(0, 0, 0, 0, 0, match_flag, ovf_flag, "R2");
      end

      // R10: clear in the same cycle as the match, set wins
      step(0, 1, 7, 0, 0, 1, 0, "R10");
      while (m_cnt != 7) step(0, 0, 0, 0, 0, 0, 0, "R10");
      step(0, 0, 0, 0, 0, 1, 0, "R10");
      chk("R10", "set_wins", int'(match_flag), 1);

      // R3: drive high on match
      step(0, 1, 90, 1, 4'b1000, 1, 1, "R3");
      chk("R3", "entry_low", int'(cmp_pin), 0);
      idle(260, "R3");
      // R8: off forces low
      step(0, 0, 0, 1, 4'b0000, 0, 0, "R8");
      chk("R8", "off_low", int'(cmp_pin), 0);
      // R4: drive low on match
      step(0, 1, 200, 1, 4'b1001, 0, 0, "R4");
      chk("R4", "entry_high", int'(cmp_pin), 1);
      idle(260, "R4");
      step(0, 0, 0, 1, 4'b1001, 0, 0, "R4");
      step(0, 0, 0, 1, 4'b0000, 0, 0, "R8");

      // R5 / R6: period trigger with several periods
      step(0, 0, 0, 0, 0, 1, 1, "R10");
      step(0, 0, 0, 1, 4'b1011, 0, 0, "R5");
      foreach (lf[k]) begin end
      for (int p = 0; p < 4; p++) begin
         int per;
         per = (p == 0) ? 1 : (p == 1) ? 5 : (p == 2) ? 40 : 170;
         step(0, 1, per, 0, 0, 1, 1, "R5");
         for (int i = 0; i < 600; i++)
            step(0, 0, 0, 0, 0, match_flag, 0, (ovf_flag ? "R6" : "R5"));
      end

      // R7: all-ones period, both flags together
      step(0, 1, MAX, 0, 0, 1, 1, "R7");
      while (m_cnt != MAX) step(0, 0, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, 0, 0, "R7");
      chk("R7", "both_flags", int'(match_flag && ovf_flag), 1);

      // R9: pseudo-random hold in trigger and drive modes
      step(0, 1, 30, 0, 0, 1, 1, "R9");
      for (int i = 0; i < 1500; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (i == 750) step(lf[0], 0, 0, 1, 4'b1000, 0, 0, "R9");
         else          step(lf[0], 0, 0, 0, 0, lf[3] & lf[5], lf[4] & lf[6], "R9");
      end
      // R9: hold exactly on the match value
      while (m_cnt != 30) step(0, 0, 0, 0, 0, 1, 0, "R9");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, "R9");
      chk("R9", "held_no_flag", int'(match_flag), 0);

      finish_run();
   end
endmodule